// File: doc/BRIEF.md
# Vector Compare to Predicate Generator

This block turns a compare-and-branch into a per-element predicate builder. A start strobe captures a compare type, two source register bases with their configured lengths, a vector length and a destination register index. The block then walks the elements one per cycle. It fetches each operand pair through two indexed register-file read ports and compares the pair. The outcome of each compare lands as one bit of a mask. When the walk ends, the mask is written back to an integer register with a single strobe.

An operand whose configured length exceeds one is treated as a vector and steps through consecutive registers. Any other operand is a scalar, and the same register is reused for every element. When neither operand is a vector, no mask is produced. The block instead returns a plain taken or not-taken branch decision.

Top module: `vec_cmp_pred`

## Requirements
- R1: After reset `busy`, `mask_we` and `br_valid` are low, and `mask_data`, `mask_waddr` and `br_taken` are zero.
- R2: An operand is a vector when its length input is greater than one. For element i a vector operand presents register (base + i) modulo NREG on its read address, and a scalar operand presents its base register for every element. The read address equals the base in the cycle after the start edge.
- R3: The walk covers exactly min(`vl`, XLEN) elements. `mask_we` is high for one cycle, beginning at the clock edge that falls min(`vl`, XLEN)+1 edges after the start edge, so `vl` = 0 writes after one edge.
- R4: Bit i of `mask_data` is 1 exactly when the compare of element i is true, and every bit at or above the effective vector length is 0.
- R5: Compare codes on `cmp_op`: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal. Codes 6 and 7 always compare false.
- R6: When both operands are scalar, `br_valid` pulses for one cycle at the first edge after the start edge. `br_taken` then gives the compare of the two base registers, and `mask_we` stays low.
- R7: `mask_waddr` equals the `dst_reg` captured at the start edge whenever `mask_we` is high.
- R8: `busy` rises at the start edge and falls at the edge that raises `mask_we` or `br_valid`. A `start` seen while `busy` is high has no effect on the running operation or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| cmp_op | input | 3 | Compare type code |
| src1_base | input | RW | First operand base register |
| src1_len | input | LW | First operand configured length |
| src2_base | input | RW | Second operand base register |
| src2_len | input | LW | Second operand configured length |
| vl | input | LW | Vector length |
| dst_reg | input | RW | Register that receives the mask |
| rf_addr1 | output | RW | Read address, first operand |
| rf_data1 | input | XLEN | Read data, first operand (same cycle) |
| rf_addr2 | output | RW | Read address, second operand |
| rf_data2 | input | XLEN | Read data, second operand (same cycle) |
| busy | output | 1 | Operation in progress |
| mask_we | output | 1 | Mask write strobe |
| mask_waddr | output | RW | Mask destination register |
| mask_data | output | XLEN | Predicate mask |
| br_valid | output | 1 | All-scalar branch decision ready |
| br_taken | output | 1 | Branch decision |

## Verification
Call the start edge E0. The read addresses are due just after E0 and advance after each following edge. The mask strobe is due after edge E(min(vl,XLEN)+1), and the branch pulse is due after E1. The bench drives inputs on falling edges and samples between edges. For the mask case it checks, at every falling edge up to the due cycle, that the strobe is still low, and then checks that it is high exactly at the due cycle. For both the strobe and the branch pulse it also confirms the pulse is gone one cycle later. In a mid-run restart test, the conflicting request must leave both the result and the due cycle of the first operation unchanged.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam logic [2:0] OP_EQ  = 3'd0;
  localparam logic [2:0] OP_NE  = 3'd1;
  localparam logic [2:0] OP_LT  = 3'd2;
  localparam logic [2:0] OP_GE  = 3'd3;
  localparam logic [2:0] OP_LTU = 3'd4;
  localparam logic [2:0] OP_GEU = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_VEC    = 2'd1,
    ST_SCALAR = 2'd2
  } vcp_state_e;
endpackage

// File: rtl/vcp_compare.sv
module vcp_compare #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  import vcp_pkg::*;

  logic eq, lts, ltu;
  assign eq  = (a == b);
  assign lts = ($signed(a) < $signed(b));
  assign ltu = (a < b);

  always_comb begin
    case (op)
      OP_EQ:   hit = eq;
      OP_NE:   hit = !eq;
      OP_LT:   hit = lts;
      OP_GE:   hit = !lts;
      OP_LTU:  hit = ltu;
      OP_GEU:  hit = !ltu;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcp_addr_gen.sv
module vcp_addr_gen #(
  parameter int RW = 5,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [RW-1:0] base,
  input  logic [LW-1:0] len,
  output logic          is_vec,
  output logic [RW-1:0] addr
);
  logic vec_q;

  assign is_vec = (len > LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      vec_q <= 1'b0;
    end else if (load) begin
      addr  <= base;
      vec_q <= is_vec;
    end else if (step && vec_q) begin
      addr <= addr + RW'(1);
    end
  end

  // R2: scalar operand keeps its register, vector operand advances by one
  p_scalar_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !vec_q) |=> $stable(addr));
  p_vector_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !load && vec_q) |=> (addr == RW'($past(addr) + RW'(1))));
endmodule

// File: rtl/vcp_mask_acc.sv
module vcp_mask_acc #(
  parameter int XLEN = 32,
  parameter int LW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [LW-1:0]   vl_eff,
  input  logic            step,
  input  logic            hit,
  output logic            done,
  output logic [XLEN-1:0] acc
);
  logic [LW-1:0] idx;
  logic [LW-1:0] vl_q;

  assign done = (idx == vl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      vl_q <= '0;
    end else if (load) begin
      idx  <= '0;
      vl_q <= vl_eff;
    end else if (step) begin
      idx <= idx + LW'(1);
    end
  end

  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || load)
        acc[g] <= 1'b0;
      else if (step && idx == LW'(g))
        acc[g] <= hit;
    end
  end

  // R3: element counter never passes the vector length
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    idx <= vl_q);
  // R4: no bit at or above the vector length is ever set
  p_high_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (acc >> vl_q) == '0);
endmodule

// File: rtl/vec_cmp_pred.sv
module vec_cmp_pred #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG),
  localparam int LW  = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      cmp_op,
  input  logic [RW-1:0]   src1_base,
  input  logic [LW-1:0]   src1_len,
  input  logic [RW-1:0]   src2_base,
  input  logic [LW-1:0]   src2_len,
  input  logic [LW-1:0]   vl,
  input  logic [RW-1:0]   dst_reg,
  output logic [RW-1:0]   rf_addr1,
  input  logic [XLEN-1:0] rf_data1,
  output logic [RW-1:0]   rf_addr2,
  input  logic [XLEN-1:0] rf_data2,
  output logic            busy,
  output logic            mask_we,
  output logic [RW-1:0]   mask_waddr,
  output logic [XLEN-1:0] mask_data,
  output logic            br_valid,
  output logic            br_taken
);
  import vcp_pkg::*;

  vcp_state_e      state;
  logic [2:0]      op_q;
  logic [RW-1:0]   dst_q;
  logic            vec1, vec2, hit, done, load, step;
  logic [LW-1:0]   vl_eff;
  logic [XLEN-1:0] acc;

  assign vl_eff = (vl > LW'(XLEN)) ? LW'(XLEN) : vl;
  assign load   = (state == ST_IDLE) && start;
  assign step   = (state == ST_VEC) && !done;

  vcp_addr_gen #(.RW(RW), .LW(LW)) u_addr1 (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .base(src1_base), .len(src1_len), .is_vec(vec1), .addr(rf_addr1));

  vcp_addr_gen #(.RW(RW), .LW(LW)) u_addr2 (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .base(src2_base), .len(src2_len), .is_vec(vec2), .addr(rf_addr2));

  vcp_compare #(.W(XLEN)) u_cmp (
    .op(op_q), .a(rf_data1), .b(rf_data2), .hit(hit));

  vcp_mask_acc #(.XLEN(XLEN), .LW(LW)) u_acc (
    .clk(clk), .rst(rst), .load(load), .vl_eff(vl_eff),
    .step(step), .hit(hit), .done(done), .acc(acc));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= '0;
      dst_q      <= '0;
      busy       <= 1'b0;
      mask_we    <= 1'b0;
      mask_waddr <= '0;
      mask_data  <= '0;
      br_valid   <= 1'b0;
      br_taken   <= 1'b0;
    end else begin
      mask_we  <= 1'b0;
      br_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q  <= cmp_op;
          dst_q <= dst_reg;
          busy  <= 1'b1;
          state <= (vec1 || vec2) ? ST_VEC : ST_SCALAR;
        end
        ST_VEC: if (done) begin
          mask_we    <= 1'b1;
          mask_data  <= acc;
          mask_waddr <= dst_q;
          busy       <= 1'b0;
          state      <= ST_IDLE;
        end
        ST_SCALAR: begin
          br_valid <= 1'b1;
          br_taken <= hit;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the write strobe is a single-cycle pulse
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> !mask_we);
  // R6: a branch decision never comes with a mask write
  p_scalar_nomask_r6: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> !mask_we);
  // R8: busy rises only on an accepted start
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R8: busy falls only together with a result
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mask_we || br_valid));
endmodule

// File: tb/vec_cmp_pred_test.sv
module vec_cmp_pred_test;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int LW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [2:0]      cmp_op = '0;
  logic [RW-1:0]   src1_base = '0, src2_base = '0, dst_reg = '0;
  logic [LW-1:0]   src1_len = '0, src2_len = '0, vl = '0;
  logic [RW-1:0]   rf_addr1, rf_addr2, mask_waddr;
  logic [XLEN-1:0] rf_data1, rf_data2, mask_data;
  logic            busy, mask_we, br_valid, br_taken;

  logic [XLEN-1:0] rf [NREG];
  int n_chk = 0;
  int n_bad = 0;

  assign rf_data1 = rf[rf_addr1];
  assign rf_data2 = rf[rf_addr2];

  always #5 clk = ~clk;

  vec_cmp_pred #(.XLEN(XLEN), .NREG(NREG)) uut (
    .clk(clk), .rst(rst), .start(start), .cmp_op(cmp_op),
    .src1_base(src1_base), .src1_len(src1_len),
    .src2_base(src2_base), .src2_len(src2_len),
    .vl(vl), .dst_reg(dst_reg),
    .rf_addr1(rf_addr1), .rf_data1(rf_data1),
    .rf_addr2(rf_addr2), .rf_data2(rf_data2),
    .busy(busy), .mask_we(mask_we), .mask_waddr(mask_waddr),
    .mask_data(mask_data), .br_valid(br_valid), .br_taken(br_taken));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_cmp(input logic [2:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (op)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) < $signed(b);
      3'd3: return $signed(a) >= $signed(b);
      3'd4: return a < b;
      3'd5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] ref_mask(input logic [2:0] op,
      input int b1, input int l1, input int b2, input int l2, input int v);
    logic [XLEN-1:0] m = '0;
    int ve = (v > XLEN) ? XLEN : v;
    for (int i = 0; i < ve; i++) begin
      int a1 = (b1 + ((l1 > 1) ? i : 0)) % NREG;
      int a2 = (b2 + ((l2 > 1) ? i : 0)) % NREG;
      m[i] = ref_cmp(op, rf[a1], rf[a2]);
    end
    return m;
  endfunction

  task automatic issue(input logic [2:0] op, input int b1, input int l1,
      input int b2, input int l2, input int v, input int d);
    @(negedge clk);
    cmp_op = op; src1_base = RW'(b1); src1_len = LW'(l1);
    src2_base = RW'(b2); src2_len = LW'(l2); vl = LW'(v); dst_reg = RW'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // vector run: checks address walk, strobe timing, mask and destination
  task automatic run_vec(input string tag, input logic [2:0] op, input int b1, input int l1,
      input int b2, input int l2, input int v, input int d, input bit chk_addr);
    logic [XLEN-1:0] exp = ref_mask(op, b1, l1, b2, l2, v);
    int ve = (v > XLEN) ? XLEN : v;
    int early = 0;
    issue(op, b1, l1, b2, l2, v, d);
    check({tag, " R8 busy after start"}, 64'(busy), 64'd1);
    for (int k = 1; k <= ve + 1; k++) begin
      if (chk_addr && k - 1 < ve) begin
        check({tag, " R2 addr1"}, 64'(rf_addr1), 64'((b1 + ((l1 > 1) ? k - 1 : 0)) % NREG));
        check({tag, " R2 addr2"}, 64'(rf_addr2), 64'((b2 + ((l2 > 1) ? k - 1 : 0)) % NREG));
      end
      if (k > 1 && mask_we) early++;
      @(negedge clk);
    end
    check({tag, " R3 no early strobe"}, 64'(early), 64'd0);
    check({tag, " R3 strobe due"}, 64'(mask_we), 64'd1);
    check({tag, " R4 mask"}, 64'(mask_data), 64'(exp));
    check({tag, " R7 waddr"}, 64'(mask_waddr), 64'(d));
    check({tag, " R8 busy cleared"}, 64'(busy), 64'd0);
    @(negedge clk);
    check({tag, " R3 strobe one cycle"}, 64'(mask_we), 64'd0);
  endtask

  task automatic run_scalar(input string tag, input logic [2:0] op, input int b1, input int b2, input int l1);
    logic exp = ref_cmp(op, rf[b1], rf[b2]);
    issue(op, b1, l1, b2, 1, 8, 3);
    check({tag, " R6 not yet valid"}, 64'(br_valid), 64'd0);
    @(negedge clk);
    check({tag, " R6 valid"}, 64'(br_valid), 64'd1);
    check({tag, " R6 taken"}, 64'(br_taken), 64'(exp));
    check({tag, " R6 no mask write"}, 64'(mask_we), 64'd0);
    check({tag, " R8 busy cleared"}, 64'(busy), 64'd0);
    @(negedge clk);
    check({tag, " R6 pulse"}, 64'(br_valid), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 mask_we", 64'(mask_we), 64'd0);
    check("R1 br_valid", 64'(br_valid), 64'd0);
    check("R1 mask_data", 64'(mask_data), 64'd0);
    check("R1 mask_waddr", 64'(mask_waddr), 64'd0);
    check("R1 br_taken", 64'(br_taken), 64'd0);
  endtask

  task automatic t_ops();
    for (int op = 0; op < 8; op++)
      run_vec("R5 op", 3'(op), 0, 6, 8, 6, 6, 9, 1'b0);
  endtask

  task automatic t_busy_ignore();
    logic [XLEN-1:0] exp = ref_mask(3'd0, 0, 8, 8, 8, 8);
    int pulses = 0;
    issue(3'd0, 0, 8, 8, 8, 8, 12);
    start = 1'b1; cmp_op = 3'd1; dst_reg = 5'd20; vl = 6'd3;
    @(negedge clk);
    start = 1'b0;
    for (int k = 2; k <= 9; k++) begin
      if (mask_we) pulses++;
      @(negedge clk);
    end
    check("R8 no early strobe", 64'(pulses), 64'd0);
    check("R8 strobe due", 64'(mask_we), 64'd1);
    check("R8 mask unchanged", 64'(mask_data), 64'(exp));
    check("R8 waddr unchanged", 64'(mask_waddr), 64'd12);
    @(negedge clk);
    check("R8 no second run", 64'(busy), 64'd0);
  endtask

  initial begin : main
    for (int i = 0; i < NREG; i++) rf[i] = XLEN'(i * 7 - 40);
    rf[8] = rf[0]; rf[10] = rf[2]; rf[13] = rf[5];
    rf[24] = 32'h0000_0005;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_vec("vv eq", 3'd0, 0, 8, 8, 8, 8, 4, 1'b1);
    run_vec("vs lt", 3'd2, 16, 8, 24, 1, 8, 5, 1'b1);
    run_vec("sv ltu", 3'd4, 24, 0, 0, 8, 8, 6, 1'b1);
    t_ops();
    run_vec("vl zero", 3'd1, 0, 4, 8, 4, 0, 7, 1'b0);
    run_vec("vl clamp", 3'd3, 0, 32, 5, 32, 40, 2, 1'b0);
    run_vec("wrap", 3'd1, 30, 4, 28, 4, 4, 1, 1'b1);
    run_scalar("sc eq taken", 3'd0, 0, 8, 1);
    run_scalar("sc ne not taken", 3'd1, 0, 8, 0);
    run_scalar("sc geu", 3'd5, 3, 24, 1);
    run_scalar("sc code7", 3'd7, 0, 0, 1);
    t_busy_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule